// File: doc/BRIEF.md
# Serial Bit-Stream Shifter on a Port Output Word

The block drives a clock-and-data serial stream out of a general-purpose output word. It is meant for loading a configuration stream into an attached programmable device. A packed configuration word picks the port bits that act as the serial clock and as serial data, and sets the bit order. A host then hands over bytes one at a time on a valid/ready handshake. Each byte goes out as eight clocked bits. Port bits outside the two masks keep whatever value the host last loaded.

For every bit the shifter runs the same three steps. It pulls the clock bits low, drives every data bit to the bit value, and then raises the clock bits. Each step lasts `PHASE_CYC` cycles, so the data is settled for at least one full cycle before the clock rises. A configuration is refused unless each mask hits at least one bit that is both writable and currently enabled as an output. A refused configuration zeroes both masks. A byte offered while either mask is zero is dropped and flagged.

The control is one state machine with four states:
- `ST_IDLE`: ready for a byte.
- `ST_CLK_LO`: clock low.
- `ST_DATA`: data driven.
- `ST_CLK_HI`: clock high.

It has five transitions:
- start: `ST_IDLE` to `ST_CLK_LO`, when a byte is taken.
- settle: `ST_CLK_LO` to `ST_DATA`, at the end of the phase.
- strobe: `ST_DATA` to `ST_CLK_HI`, at the end of the phase.
- next-bit: `ST_CLK_HI` to `ST_CLK_LO`, at the end of the phase when bits remain.
- finish: `ST_CLK_HI` to `ST_IDLE`, after the eighth bit.

Top module: `ser_port_writer`

## Requirements
- R1: After reset `port_out` is all zeros, `byte_ready` is 1, `byte_done`, `wr_err` and `cfg_err` are 0, and both masks are zero.
- R2: A `cfg_we` pulse in `ST_IDLE` reads `cfg_word` as clock mask in bits [7:0] (port bits 7..0), data mask in bits [15:8] and an MSB-first flag in bit 16. The word is stored when each mask overlaps `WRITABLE` and also overlaps `oe`.
- R3: A configuration that fails the R2 test stores zero masks and raises `cfg_err` for exactly one cycle after the write.
- R4: A byte offered in `ST_IDLE` while either mask is zero is consumed without shifting. `wr_err` pulses for one cycle, `port_out` stays unchanged and `byte_ready` stays 1.
- R5: For each bit, the clock bits go low for `PHASE_CYC` cycles starting the cycle after acceptance. Then all data-mask bits take the bit value for `PHASE_CYC` cycles. Then the clock bits go high for `PHASE_CYC` cycles.
- R6: With the MSB-first flag set, bits go out 7 down to 0. With it clear, they go out 0 up to 7.
- R7: During a byte, port bits outside both masks never change.
- R8: `byte_ready` is 0 for exactly 24*`PHASE_CYC` cycles after the accepting edge.
- R9: `byte_done` is 1 for exactly one cycle, the first cycle back in `ST_IDLE`. At that point the clock bits are high and the data bits hold the last bit.
- R10: `cfg_we` and `port_we` asserted while a byte is shifting have no effect: no `cfg_err`, masks kept, `port_out` following R5.
- R11: A `port_we` pulse in `ST_IDLE` with no byte being taken loads `port_wdata` into the `WRITABLE` bits of the output word only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 17 | Packed clock mask, data mask, MSB-first flag |
| cfg_err | output | 1 | One-cycle pulse on a refused configuration |
| oe | input | PORT_W | Current output-enable mask of the port |
| port_we | input | 1 | Host load strobe for the output word |
| port_wdata | input | PORT_W | Value for the host load |
| byte_valid | input | 1 | Byte offered |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Shifter idle, byte can be taken |
| byte_done | output | 1 | One-cycle pulse after the eighth bit |
| wr_err | output | 1 | One-cycle pulse on a byte refused for zero masks |
| port_out | output | PORT_W | Output word driving the port |

## Verification
The bench builds the block with a 12-bit port, `PHASE_CYC` of 2 and a writable mask of `12'hEDF`. These values make bit 5 and bit 8 read-only. That brings a mask aimed only at a read-only bit within reach, and it shows that host loads skip those bits. A phase length of two checks that the phase counter truly stretches each step, where a length of one would hide an off-by-one. The port is wider than the masks, so the upper bits exercise the rule that unselected bits stay put.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
    localparam int MASK_W = 8;
    localparam int BYTE_W = 8;
    localparam int CFG_W  = 2 * MASK_W + 1;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_DATA,
        ST_CLK_HI
    } ssw_state_t;

    typedef struct packed {
        logic              msb_first;
        logic [MASK_W-1:0] dat_mask;
        logic [MASK_W-1:0] clk_mask;
    } ssw_cfg_t;
endpackage

// File: rtl/ssw_cfg_reg.sv
module ssw_cfg_reg
    import ssw_pkg::*;
#(
    parameter int                PORT_W   = 18,
    parameter logic [PORT_W-1:0] WRITABLE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_word,
    input  logic [PORT_W-1:0] oe,
    output ssw_cfg_t          cfg_o,
    output logic              reject_o
);
    localparam logic [MASK_W-1:0] WR_LO = WRITABLE[MASK_W-1:0];

    ssw_cfg_t req;
    ssw_cfg_t cfg_q;
    logic     reject_q;
    logic     fits;

    always_comb begin
        req  = ssw_cfg_t'(wr_word);
        fits = (|(req.clk_mask & WR_LO)) &&
               (|(req.dat_mask & WR_LO)) &&
               (|(req.clk_mask & oe[MASK_W-1:0])) &&
               (|(req.dat_mask & oe[MASK_W-1:0]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= wr_en && !fits;
            if (wr_en) begin
                cfg_q <= fits ? req : '0;
            end
        end
    end

    assign cfg_o    = cfg_q;
    assign reject_o = reject_q;

    AST_REJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reject_q |-> (cfg_q.clk_mask == '0) && (cfg_q.dat_mask == '0)); // R3

    AST_CFG_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.clk_mask != '0) |-> (|(cfg_q.clk_mask & WR_LO)) && (|(cfg_q.dat_mask & WR_LO))); // R2
endmodule

// File: rtl/ssw_phase_timer.sv
module ssw_phase_timer #(
    parameter int PHASE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic phase_end
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign phase_end = !hold && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < PHASE_CYC); // R5
endmodule

// File: rtl/ssw_bit_sel.sv
module ssw_bit_sel
    import ssw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              msb_first,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              bit_o,
    output logic              last_o
);
    logic [BYTE_W-1:0] byte_q;
    logic [IDX_W-1:0]  idx_q;
    logic              msb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx_q  <= '0;
            msb_q  <= 1'b0;
        end else if (load) begin
            byte_q <= byte_in;
            idx_q  <= '0;
            msb_q  <= msb_first;
        end else if (step) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign bit_o  = msb_q ? byte_q[~idx_q] : byte_q[idx_q];
    assign last_o = &idx_q;
endmodule

// File: rtl/ser_port_writer.sv
module ser_port_writer
    import ssw_pkg::*;
#(
    parameter int                PORT_W    = 18,
    parameter int                PHASE_CYC = 1,
    parameter logic [PORT_W-1:0] WRITABLE  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              cfg_err,
    input  logic [PORT_W-1:0] oe,
    input  logic              port_we,
    input  logic [PORT_W-1:0] port_wdata,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    output logic              byte_done,
    output logic              wr_err,
    output logic [PORT_W-1:0] port_out
);
    ssw_state_t        state_q, state_d;
    ssw_cfg_t          cfg;
    logic              idle, masks_ok, accept, refuse;
    logic              phase_end, cur_bit, last_bit;
    logic [PORT_W-1:0] clk_w, dat_w, shadow_q;
    logic              done_q, wr_err_q;

    assign idle     = (state_q == ST_IDLE);
    assign masks_ok = (|cfg.clk_mask) && (|cfg.dat_mask);
    assign accept   = idle && byte_valid && masks_ok;
    assign refuse   = idle && byte_valid && !masks_ok;
    assign clk_w    = PORT_W'(cfg.clk_mask);
    assign dat_w    = PORT_W'(cfg.dat_mask);

    ssw_cfg_reg #(
        .PORT_W   (PORT_W),
        .WRITABLE (WRITABLE)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && idle),
        .wr_word  (cfg_word),
        .oe       (oe),
        .cfg_o    (cfg),
        .reject_o (cfg_err)
    );

    ssw_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (idle),
        .phase_end (phase_end)
    );

    ssw_bit_sel u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      ((state_q == ST_CLK_HI) && phase_end),
        .msb_first (cfg.msb_first),
        .byte_in   (byte_data),
        .bit_o     (cur_bit),
        .last_o    (last_bit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_CLK_LO;
            ST_CLK_LO: if (phase_end) state_d = ST_DATA;
            ST_DATA:   if (phase_end) state_d = ST_CLK_HI;
            ST_CLK_HI: if (phase_end) state_d = last_bit ? ST_IDLE : ST_CLK_LO;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs: shadow word read-modify-write and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            done_q   <= 1'b0;
            wr_err_q <= 1'b0;
        end else begin
            done_q   <= (state_q == ST_CLK_HI) && phase_end && last_bit;
            wr_err_q <= refuse;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        shadow_q <= shadow_q & ~clk_w;
                    end else if (port_we) begin
                        shadow_q <= (shadow_q & ~WRITABLE) | (port_wdata & WRITABLE);
                    end
                end
                ST_CLK_LO: begin
                    if (phase_end) begin
                        shadow_q <= cur_bit ? (shadow_q | dat_w) : (shadow_q & ~dat_w);
                    end
                end
                ST_DATA: begin
                    if (phase_end) begin
                        shadow_q <= shadow_q | clk_w;
                    end
                end
                ST_CLK_HI: begin
                    if (phase_end && !last_bit) begin
                        shadow_q <= shadow_q & ~clk_w;
                    end
                end
                default: shadow_q <= shadow_q;
            endcase
        end
    end

    assign byte_ready = idle;
    assign byte_done  = done_q;
    assign wr_err     = wr_err_q;
    assign port_out   = shadow_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R9

    AST_DONE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> ((port_out & clk_w) == clk_w) && byte_ready); // R9

    AST_REFUSE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && !$past(port_we)) |-> (port_out == $past(port_out))); // R4

    AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_ready |-> (((port_out ^ $past(port_out)) & ~(clk_w | dat_w)) == '0)); // R7

    AST_CFG_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(byte_ready)); // R10
endmodule

// File: tb/ser_port_writer_bench.sv
`timescale 1ns/1ps
module ser_port_writer_bench;
    localparam int              PW  = 12;
    localparam int              PH  = 2;
    localparam logic [PW-1:0]   WRM = 12'hEDF;
    localparam int              NB  = 24 * PH;

    // row: {accept, byte, oe, cfg_word{msb, data mask, clock mask}}
    localparam logic [37:0] VEC [8] = '{
        {1'b1, 8'hA5, 12'hFFF, 17'h10201},
        {1'b1, 8'h3C, 12'hFFF, 17'h00804},
        {1'b0, 8'h55, 12'hFFF, 17'h10120},
        {1'b0, 8'h55, 12'h0EF, 17'h01001},
        {1'b1, 8'h81, 12'hFFF, 17'h0C003},
        {1'b1, 8'h6E, 12'hFFF, 17'h14021},
        {1'b0, 8'h55, 12'hFFF, 17'h00200},
        {1'b1, 8'h96, 12'h0C3, 17'h18002}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [16:0]   cfg_word = '0;
    logic          cfg_err;
    logic [PW-1:0] oe_in = '1;
    logic          port_we = 1'b0;
    logic [PW-1:0] port_wdata = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          byte_ready, byte_done, wr_err;
    logic [PW-1:0] port_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ser_port_writer #(
        .PORT_W    (PW),
        .PHASE_CYC (PH),
        .WRITABLE  (WRM)
    ) u_ser_port_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_word   (cfg_word),
        .cfg_err    (cfg_err),
        .oe         (oe_in),
        .port_we    (port_we),
        .port_wdata (port_wdata),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .byte_done  (byte_done),
        .wr_err     (wr_err),
        .port_out   (port_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected port word n cycles after the accepting edge, built from the phase rules
    function automatic logic [PW-1:0] exp_port(input logic [PW-1:0] pre, input logic [7:0] b8,
                                               input logic msb, input logic [PW-1:0] cm,
                                               input logic [PW-1:0] dm, input int n);
        logic [PW-1:0] v;
        int bi;
        int ph;
        v = pre;
        if (n >= NB) begin
            bi = 7;
            ph = 2;
        end else begin
            bi = n / (3 * PH);
            ph = (n % (3 * PH)) / PH;
        end
        for (int k = 0; k <= bi; k++) begin
            logic bv;
            bv = msb ? b8[7 - k] : b8[k];
            v = v & ~cm;
            if (k < bi || ph >= 1) v = bv ? (v | dm) : (v & ~dm);
            if (k < bi || ph == 2) v = v | cm;
        end
        return v;
    endfunction

    // send one accepted byte and check every cycle; disturb pokes cfg/port writes mid-byte
    task automatic send_seq(input logic [7:0] b8, input logic msb, input logic [PW-1:0] cm,
                            input logic [PW-1:0] dm, input bit disturb);
        logic [PW-1:0] pre;
        logic [PW-1:0] e;
        pre = port_out;
        byte_valid = 1'b1;
        byte_data  = b8;
        @(negedge clk);
        byte_valid = 1'b0;
        for (int n = 0; n <= NB; n++) begin
            e = exp_port(pre, b8, msb, cm, dm, n);
            chk(port_out == e, "R5 R6 R7 port sequence", 32'(port_out), 32'(e));
            chk(byte_ready == (n == NB), "R8 ready", 32'(byte_ready), 32'(n == NB));
            chk(byte_done == (n == NB), "R9 done", 32'(byte_done), 32'(n == NB));
            chk(cfg_err == 1'b0, "R10 cfg_err while busy", 32'(cfg_err), 32'h0);
            if (disturb && n == 5) begin
                cfg_we     = 1'b1;
                cfg_word   = 17'h00000;
                port_we    = 1'b1;
                port_wdata = '0;
            end else begin
                cfg_we  = 1'b0;
                port_we = 1'b0;
            end
            if (n < NB) @(negedge clk);
        end
        @(negedge clk);
        chk(byte_done == 1'b0, "R9 done one cycle", 32'(byte_done), 32'h0);
    endtask

    // offer a byte while masks are zero
    task automatic send_refused(input logic [7:0] b8);
        logic [PW-1:0] pre;
        pre = port_out;
        byte_valid = 1'b1;
        byte_data  = b8;
        @(negedge clk);
        byte_valid = 1'b0;
        chk(wr_err == 1'b1, "R4 wr_err", 32'(wr_err), 32'h1);
        chk(byte_ready == 1'b1, "R4 ready kept", 32'(byte_ready), 32'h1);
        chk(port_out == pre, "R4 port unchanged", 32'(port_out), 32'(pre));
        @(negedge clk);
        chk(wr_err == 1'b0, "R4 wr_err one cycle", 32'(wr_err), 32'h0);
        chk(port_out == pre, "R4 port still unchanged", 32'(port_out), 32'(pre));
    endtask

    task automatic write_cfg(input logic [16:0] w, input logic [PW-1:0] o, input bit ok);
        cfg_we   = 1'b1;
        cfg_word = w;
        oe_in    = o;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ok) chk(cfg_err == 1'b0, "R2 accepted cfg", 32'(cfg_err), 32'h0);
        else    chk(cfg_err == 1'b1, "R3 refused cfg", 32'(cfg_err), 32'h1);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R3 cfg_err one cycle", 32'(cfg_err), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(port_out == '0, "R1 port", 32'(port_out), 32'h0);
        chk(byte_ready == 1'b1, "R1 ready", 32'(byte_ready), 32'h1);
        chk(byte_done == 1'b0, "R1 done", 32'(byte_done), 32'h0);
        chk(wr_err == 1'b0, "R1 wr_err", 32'(wr_err), 32'h0);
        chk(cfg_err == 1'b0, "R1 cfg_err", 32'(cfg_err), 32'h0);
        // R1 masks zero after reset, so a byte is refused (R4)
        send_refused(8'hF0);

        // R11 host load only reaches writable bits
        port_we    = 1'b1;
        port_wdata = 12'hFFF;
        @(negedge clk);
        port_we = 1'b0;
        chk(port_out == 12'hEDF, "R11 host load", 32'(port_out), 32'hEDF);

        // table walk: configuration outcome, then byte sequence or refusal (R2 R3 R4 R5 R6)
        for (int i = 0; i < 8; i++) begin
            logic [37:0] row;
            row = VEC[i];
            write_cfg(row[16:0], row[28:17], row[37]);
            if (row[37]) send_seq(row[36:29], row[16], PW'(row[7:0]), PW'(row[15:8]), 1'b0);
            else         send_refused(row[36:29]);
        end

        // R10 config and host writes during a byte are ignored; masks survive
        write_cfg(17'h10201, 12'hFFF, 1'b1);
        send_seq(8'hC3, 1'b1, 12'h001, 12'h002, 1'b1);
        send_seq(8'h5A, 1'b1, 12'h001, 12'h002, 1'b0);

        // R6 same byte in both orders
        write_cfg(17'h00201, 12'hFFF, 1'b1);
        send_seq(8'h01, 1'b0, 12'h001, 12'h002, 1'b0);
        write_cfg(17'h10201, 12'hFFF, 1'b1);
        send_seq(8'h01, 1'b1, 12'h001, 12'h002, 1'b0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule